// File: doc/BRIEF.md
# Counting Interrupt Controller

This block gathers 32 level-type interrupt lines and presents them to a parent processor on two outputs, a normal interrupt request and a fast interrupt request. Each line is watched for edges. A rising input sets that source's latched level bit, and a falling input clears it. A separate mask decides which latched sources raise the normal request. A second mask, fixed by a parameter, decides which latched sources raise the fast request.

Besides the mask, the controller keeps a running tally of sources that are both latched and enabled. The tally is adjusted step by step as lines move and as software enables or disables sources. Software uses a simple strobe bus to read the tally and the number of the lowest enabled pending source. Over the same bus it can switch one source on or off by writing that source's index, or wipe all latched state at once.

Top module: `tally_intc`

## Requirements
- R1: After a synchronous active-high reset, the tally, all level bits and all enable bits are zero, both request outputs are low, and a tally read returns 0.
- R2: A level bit is set on a 0-to-1 change of its input and cleared on a 1-to-0 change, each seen against the previous cycle's input. An input that holds its value has no effect. A line still high after a clear-all stays cleared until it falls and rises again.
- R3: The tally rises by one when an enabled source's level bit goes 0 to 1 and falls by one when it goes 1 to 0. It always equals the number of sources both latched and enabled, and never exceeds the source count.
- R4: A read (`bus_sel`=1, `bus_wr`=0) at byte offset 0x00 returns the tally, zero-extended, on `bus_rdata` in the same cycle.
- R5: A read at offset 0x04 returns the index of the lowest-numbered bit set in (level AND enable), or 0 when none is set, in the same cycle.
- R6: A write at offset 0x08 clears the tally and every level bit on the next edge and leaves the enable mask unchanged.
- R7: A write at offset 0x0C with index n in the low 5 bits of `bus_wdata` has an effect only if source n is enabled. It clears enable bit n and lowers the tally by one if level bit n is set. Upper data bits are ignored.
- R8: A write at offset 0x10 with index n in the low 5 bits has an effect only if source n is disabled. It sets enable bit n and raises the tally by one if level bit n is set.
- R9: `irq_out` is high exactly when (level AND enable) is nonzero. `fiq_out` is high exactly when (level AND `FIQ_PRESET`) is nonzero. Both follow the state one cycle after the edge that changed it.
- R10: When an input edge and a register write fall in the same cycle, the input change is applied first and the write acts on the updated level bits.
- R11: Any strobed access other than a read of 0x00 or 0x04, or a write of 0x08, 0x0C or 0x10, has no effect. For such an access `bus_rdata` is 0 and `bus_err` is high in the same cycle. This covers other offsets, misaligned offsets and the wrong direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Interrupt source lines |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wdata | input | 32 | Write data (source index in low bits) |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bus_err | output | 1 | High for a strobed access that is not decoded |
| irq_out | output | 1 | Normal interrupt request to the parent |
| fiq_out | output | 1 | Fast interrupt request to the parent |

## Verification
An edge on an input line and an enable, disable or clear-all write can land in the same clock, and the order in which they apply decides the tally. The bench drives a line's rising or falling edge in the same cycle as a write that names that same source. It then reads the tally and the lowest-source register back. A behavioural reference model that first applies the edge and then the write predicts the values. The same model is compared against both request outputs and the bus response on every clock during a long random mix of edges and accesses.

// File: rtl/tally_intc_pkg.sv
package tally_intc_pkg;

    // byte offsets of the decoded words
    localparam int unsigned OFS_TALLY  = 'h000;
    localparam int unsigned OFS_LOWEST = 'h004;
    localparam int unsigned OFS_WIPE   = 'h008;
    localparam int unsigned OFS_MASKOF = 'h00C;
    localparam int unsigned OFS_MASKON = 'h010;

    // widest supported source index
    localparam int unsigned IDX_MAX_W = 8;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_RD_TALLY,
        OP_RD_LOWEST,
        OP_WIPE,
        OP_MASK_OFF,
        OP_MASK_ON,
        OP_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e             kind;
        logic [IDX_MAX_W-1:0] idx;
    } bus_op_t;

    function automatic logic is_write_op(input op_kind_e k);
        return (k == OP_WIPE) || (k == OP_MASK_OFF) || (k == OP_MASK_ON);
    endfunction

endpackage

// File: rtl/tally_intc_edge.sv
module tally_intc_edge #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] din,
    output logic [N_SRC-1:0] prev_o,
    output logic [N_SRC-1:0] rise_o,
    output logic [N_SRC-1:0] fall_o
);
    logic [N_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        assign rise_o[i] = din[i] & ~prev_q[i];
        assign fall_o[i] = ~din[i] & prev_q[i];
    end

    assign prev_o = prev_q;
endmodule

// File: rtl/tally_intc_decode.sv
module tally_intc_decode
    import tally_intc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 5
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  idx_in,
    output bus_op_t           op_o,
    output logic              err_o
);
    localparam logic [ADDR_W-1:0] A_TALLY  = ADDR_W'(OFS_TALLY);
    localparam logic [ADDR_W-1:0] A_LOWEST = ADDR_W'(OFS_LOWEST);
    localparam logic [ADDR_W-1:0] A_WIPE   = ADDR_W'(OFS_WIPE);
    localparam logic [ADDR_W-1:0] A_MASKOF = ADDR_W'(OFS_MASKOF);
    localparam logic [ADDR_W-1:0] A_MASKON = ADDR_W'(OFS_MASKON);

    op_kind_e kind;

    always_comb begin
        kind = OP_IDLE;
        if (sel) begin
            kind = OP_BAD;
            if (!wr) begin
                if (addr == A_TALLY)       kind = OP_RD_TALLY;
                else if (addr == A_LOWEST) kind = OP_RD_LOWEST;
            end else begin
                if (addr == A_WIPE)        kind = OP_WIPE;
                else if (addr == A_MASKOF) kind = OP_MASK_OFF;
                else if (addr == A_MASKON) kind = OP_MASK_ON;
            end
        end
    end

    assign op_o.kind = kind;
    assign op_o.idx  = IDX_MAX_W'(idx_in);
    assign err_o     = (kind == OP_BAD);
endmodule

// File: rtl/tally_intc_lowest.sv
module tally_intc_lowest #(
    parameter int N_SRC = 32,
    parameter int IDX_W = 5
) (
    input  logic [N_SRC-1:0] vec,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    logic [N_SRC-1:0] first;

    for (genvar i = 0; i < N_SRC; i++) begin : g_scan
        logic lower;
        if (i == 0) begin : g_head
            assign lower = 1'b0;
        end else begin : g_tail
            assign lower = g_scan[i-1].lower | vec[i-1];
        end
        assign first[i] = vec[i] & ~lower;
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (first[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign any_o = |vec;
endmodule

// File: rtl/tally_intc_core.sv
module tally_intc_core
    import tally_intc_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int IDX_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] rise,
    input  logic [N_SRC-1:0] fall,
    input  bus_op_t          op,
    output logic [N_SRC-1:0] level_o,
    output logic [N_SRC-1:0] irq_en_o,
    output logic [CNT_W-1:0] tally_o
);
    logic [N_SRC-1:0] level_q, level_n;
    logic [N_SRC-1:0] en_q, en_n;
    logic [CNT_W-1:0] tally_q, tally_n, tally_mid;
    logic [CNT_W-1:0] up_cnt, dn_cnt;
    logic [IDX_W-1:0] sidx;
    logic             idx_ok;
    logic             unused_idx_hi;

    assign sidx          = op.idx[IDX_W-1:0];
    assign idx_ok        = ({1'b0, sidx} < (IDX_W+1)'(N_SRC));
    assign unused_idx_hi = ^op.idx[IDX_MAX_W-1:IDX_W];

    // step 1: input edges
    always_comb begin
        level_n   = (level_q | rise) & ~fall;
        up_cnt    = CNT_W'($countones(rise & ~level_q & en_q));
        dn_cnt    = CNT_W'($countones(fall & level_q & en_q));
        tally_mid = tally_q + up_cnt - dn_cnt;
        en_n      = en_q;
        tally_n   = tally_mid;
        // step 2: register write on the updated state
        case (op.kind)
            OP_WIPE: begin
                level_n = '0;
                tally_n = '0;
            end
            OP_MASK_OFF: begin
                if (idx_ok && en_q[sidx]) begin
                    en_n[sidx] = 1'b0;
                    if (level_n[sidx]) tally_n = tally_mid - 1'b1;
                end
            end
            OP_MASK_ON: begin
                if (idx_ok && !en_q[sidx]) begin
                    en_n[sidx] = 1'b1;
                    if (level_n[sidx]) tally_n = tally_mid + 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            en_q    <= '0;
            tally_q <= '0;
        end else begin
            level_q <= level_n;
            en_q    <= en_n;
            tally_q <= tally_n;
        end
    end

    assign level_o  = level_q;
    assign irq_en_o = en_q;
    assign tally_o  = tally_q;
endmodule

// File: rtl/tally_intc.sv
module tally_intc
    import tally_intc_pkg::*;
#(
    parameter int               N_SRC      = 32,
    parameter int               ADDR_W     = 12,
    parameter int               DATA_W     = 32,
    parameter logic [N_SRC-1:0] FIQ_PRESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq_out,
    output logic              fiq_out
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int CNT_W = $clog2(N_SRC + 1);

    logic [N_SRC-1:0] prev_w, rise_w, fall_w;
    logic [N_SRC-1:0] level_w, irq_en_w, pend_w;
    logic [CNT_W-1:0] tally_w;
    logic [IDX_W-1:0] lowest_w;
    logic             any_w;
    bus_op_t          op_w;
    logic             err_w;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:IDX_W];

    tally_intc_edge #(.N_SRC(N_SRC)) u_edge (
        .clk(clk), .rst(rst), .din(src_in),
        .prev_o(prev_w), .rise_o(rise_w), .fall_o(fall_w)
    );

    tally_intc_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .idx_in(bus_wdata[IDX_W-1:0]), .op_o(op_w), .err_o(err_w)
    );

    tally_intc_core #(.N_SRC(N_SRC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .rise(rise_w), .fall(fall_w), .op(op_w),
        .level_o(level_w), .irq_en_o(irq_en_w), .tally_o(tally_w)
    );

    assign pend_w = level_w & irq_en_w;

    tally_intc_lowest #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_low (
        .vec(pend_w), .idx_o(lowest_w), .any_o(any_w)
    );

    always_comb begin
        case (op_w.kind)
            OP_RD_TALLY:  bus_rdata = DATA_W'(tally_w);
            OP_RD_LOWEST: bus_rdata = DATA_W'(lowest_w);
            default:      bus_rdata = '0;
        endcase
    end

    assign bus_err = err_w;
    assign irq_out = any_w;
    assign fiq_out = |(level_w & FIQ_PRESET);
endmodule

// File: rtl/tally_intc_chk.sv
module tally_intc_chk
    import tally_intc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [N_SRC-1:0]  src_in,
    input logic [N_SRC-1:0]  prev_q,
    input logic [N_SRC-1:0]  level,
    input logic [N_SRC-1:0]  irq_en,
    input logic [CNT_W-1:0]  tally,
    input bus_op_t           op,
    input logic              irq_out,
    input logic              bus_err,
    input logic [DATA_W-1:0] bus_rdata
);
    logic [IDX_W-1:0] sidx;
    logic             unused_chk;
    assign sidx       = op.idx[IDX_W-1:0];
    assign unused_chk = ^op.idx;

    assert_tally_tracks_R3: assert property (@(posedge clk) disable iff (rst)
        32'(tally) == 32'($countones(level & irq_en)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        32'(tally) <= 32'(N_SRC));

    assert_irq_vs_tally_R9: assert property (@(posedge clk) disable iff (rst)
        irq_out == (tally != '0));

    assert_wipe_clears_R6: assert property (@(posedge clk) disable iff (rst)
        op.kind == OP_WIPE |=> (level == '0) && (tally == '0));

    assert_wipe_keeps_mask_R6: assert property (@(posedge clk) disable iff (rst)
        op.kind == OP_WIPE |=> $stable(irq_en));

    assert_mask_off_R7: assert property (@(posedge clk) disable iff (rst)
        op.kind == OP_MASK_OFF |=> !irq_en[$past(sidx)]);

    assert_mask_on_R8: assert property (@(posedge clk) disable iff (rst)
        op.kind == OP_MASK_ON |=> irq_en[$past(sidx)]);

    assert_quiet_inputs_R2: assert property (@(posedge clk) disable iff (rst)
        (!is_write_op(op.kind) && src_in == prev_q) |=> $stable(level) && $stable(tally));

    assert_bad_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_rdata == '0);

    assert_bad_no_effect_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_err && src_in == prev_q) |=> $stable(irq_en) && $stable(level) && $stable(tally));
endmodule

bind tally_intc tally_intc_chk #(
    .N_SRC(N_SRC), .IDX_W(IDX_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst), .src_in(src_in), .prev_q(prev_w),
    .level(level_w), .irq_en(irq_en_w), .tally(tally_w), .op(op_w),
    .irq_out(irq_out), .bus_err(bus_err), .bus_rdata(bus_rdata)
);

// File: tb/sim_tally_intc.sv
`timescale 1ns/1ps
module sim_tally_intc;
    localparam logic [31:0] FIQP = 32'h8000_0011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, irq_out, fiq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_prev = '0, m_lvl = '0, m_en = '0;
    int          m_cnt = 0;

    always #5 clk = ~clk;

    tally_intc #(.FIQ_PRESET(FIQP)) u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest_of(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    // one clock: drive, compare against model, advance model
    task automatic step(input string tag, input logic sel, input logic wr,
                        input logic [11:0] addr, input logic [31:0] wd, input logic [31:0] src);
        logic        good;
        logic [31:0] exp_rd;
        int          n;
        @(negedge clk);
        #1;
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd; src_in = src;
        #2;
        good = sel && ((!wr && (addr == 12'h000 || addr == 12'h004)) ||
                       (wr && (addr == 12'h008 || addr == 12'h00C || addr == 12'h010)));
        exp_rd = '0;
        if (sel && !wr && addr == 12'h000) exp_rd = 32'(m_cnt);
        if (sel && !wr && addr == 12'h004) exp_rd = 32'(lowest_of(m_lvl & m_en));
        chk("R9", "irq_out", 32'(irq_out), 32'(|(m_lvl & m_en)));
        chk("R9", "fiq_out", 32'(fiq_out), 32'(|(m_lvl & FIQP)));
        chk("R11", "bus_err", 32'(bus_err), 32'(sel && !good));
        chk(tag, "bus_rdata", bus_rdata, exp_rd);
        // model: edges first, then the write
        for (int i = 0; i < 32; i++) begin
            if (src[i] && !m_prev[i] && !m_lvl[i]) begin
                if (m_en[i]) m_cnt++;
                m_lvl[i] = 1'b1;
            end else if (!src[i] && m_prev[i] && m_lvl[i]) begin
                if (m_en[i]) m_cnt--;
                m_lvl[i] = 1'b0;
            end
        end
        m_prev = src;
        if (sel && wr) begin
            n = int'(wd[4:0]);
            if (addr == 12'h008) begin
                m_cnt = 0; m_lvl = '0;
            end else if (addr == 12'h00C && m_en[n]) begin
                m_en[n] = 1'b0;
                if (m_lvl[n]) m_cnt--;
            end else if (addr == 12'h010 && !m_en[n]) begin
                m_en[n] = 1'b1;
                if (m_lvl[n]) m_cnt++;
            end
        end
    endtask

    task automatic idle(input logic [31:0] src);
        step("R2", 1'b0, 1'b0, 12'h000, '0, src);
    endtask
    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] src);
        step(tag, 1'b1, 1'b0, a, '0, src);
    endtask
    task automatic wr_op(input string tag, input logic [11:0] a, input logic [31:0] d, input logic [31:0] src);
        step(tag, 1'b1, 1'b1, a, d, src);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog run did not end actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] s;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        rd("R1", 12'h000, '0);
        rd("R1", 12'h004, '0);
        // R2 / R3: latch without enable gives no tally
        s = 32'h0000_0024;
        idle(s);
        rd("R3", 12'h000, s);
        // R8 enable 5 with level high
        wr_op("R8", 12'h010, 32'd5, s);
        rd("R8", 12'h000, s);
        rd("R5", 12'h004, s);
        wr_op("R8", 12'h010, 32'd2, s);
        rd("R5", 12'h004, s);
        rd("R4", 12'h000, s);
        // R8 enable twice: no second count
        wr_op("R8", 12'h010, 32'd2, s);
        rd("R8", 12'h000, s);
        // R3 falling enabled source
        s = 32'h0000_0020;
        idle(s);
        rd("R3", 12'h000, s);
        rd("R5", 12'h004, s);
        // R7 disable, then disable again
        wr_op("R7", 12'h00C, 32'd5, s);
        rd("R7", 12'h000, s);
        wr_op("R7", 12'h00C, 32'd5, s);
        rd("R7", 12'h000, s);
        // R7/R8 upper data bits ignored: 0xFFFFFFE5 -> index 5
        wr_op("R8", 12'h010, 32'hFFFF_FFE5, s);
        rd("R8", 12'h000, s);
        // R9 fiq from preset bit 0, not enabled for irq
        s = s | 32'h0000_0001;
        idle(s); idle(s);
        rd("R9", 12'h004, s);
        // R6 wipe while lines held high
        wr_op("R6", 12'h008, 32'd0, s);
        rd("R6", 12'h000, s);
        rd("R6", 12'h004, s);
        // R2 held line stays cleared until it re-rises
        idle(s);
        rd("R2", 12'h000, s);
        s = s & ~32'h0000_0020; idle(s);
        s = s | 32'h0000_0020; idle(s);
        rd("R2", 12'h000, s);
        // R10 same-cycle rise and enable of source 7
        s = s | 32'h0000_0080;
        wr_op("R10", 12'h010, 32'd7, s);
        rd("R10", 12'h000, s);
        // R10 same-cycle fall and disable of source 7
        s = s & ~32'h0000_0080;
        wr_op("R10", 12'h00C, 32'd7, s);
        rd("R10", 12'h000, s);
        // R10 same-cycle rise and wipe
        s = s | 32'h0000_0100;
        wr_op("R10", 12'h008, 32'd0, s);
        rd("R10", 12'h000, s);
        // R11 undecoded accesses
        rd("R11", 12'h008, s);
        rd("R11", 12'h010, s);
        rd("R11", 12'h014, s);
        rd("R11", 12'h002, s);
        wr_op("R11", 12'h000, 32'd3, s);
        wr_op("R11", 12'h004, 32'd3, s);
        wr_op("R11", 12'h011, 32'd3, s);
        rd("R11", 12'h000, s);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            r = $urandom;
            if (r[3:0] < 4'd5) s = s ^ (32'h1 << $urandom_range(0, 31));
            case ($urandom_range(0, 9))
                0: wr_op("R8", 12'h010, $urandom, s);
                1: wr_op("R7", 12'h00C, $urandom, s);
                2: if (r[9:6] == 4'd0) wr_op("R6", 12'h008, '0, s); else idle(s);
                3: rd("R4", 12'h000, s);
                4: rd("R5", 12'h004, s);
                5: rd("R11", 12'(4 * $urandom_range(0, 8)), s);
                6: wr_op("R8", 12'h010, 32'($urandom_range(0, 7)), s);
                default: idle(s);
            endcase
        end
        rd("R3", 12'h000, s);
        finish_run();
    end
endmodule